// File: doc/BRIEF.md
# Crossing-Indexed Hit History Buffer

This block keeps detector hits sorted by the beam crossing they belong to, for a fixed window of recent crossings. A ring of small per-crossing queues, called slots, forms that window. Each hit arrives with a crossing tag. The low bits of the tag pick a slot, and the hit is appended there after a fixed write pipeline. Each slot also records the full tag it currently holds. The first hit of a new crossing that lands on a slot still holding an older crossing clears that slot before the hit is stored.

When the trigger arrives, the block does not use a read pointer of its own. It works out which crossing to read by subtracting a fixed trigger latency from the current crossing counter, with wrap-around. If the matching slot holds that crossing, its words stream out in write order, and the final word is marked. If the slot holds a different crossing or nothing, no words are sent, and the block reports an empty readout. Either way a one-cycle done pulse closes the readout. Writes and readouts run concurrently.

The hit input is never back-pressured: `in_ready` is tied high, and a hit aimed at a full slot is dropped and recorded in a sticky flag. The read output is valid/ready. A word stays on the port, unchanged, until it is accepted, and the slot contents are not consumed by the read.

Top module: `hit_history_buf`

## Requirements
- R1: While reset is asserted and right after it is released: `out_valid`, `rd_done`, `rd_empty` and `overflow` are 0, and `in_ready` is 1.
- R2: A trigger sampled with counter value B reads the crossing T = (B − TRIG_LAT) mod 2^BCO_W. It emits every stored word of T in write order. `out_last` is 1 on the final word only. `rd_done` pulses for one cycle, one cycle after the final word is accepted.
- R3: The slot is the low log2(NSLOT) bits of the tag. The subtraction in R2 wraps through zero, so a counter value below TRIG_LAT reads a crossing near the top of the tag range.
- R4: If the selected slot holds no words of T, no word is emitted. `rd_done` and `rd_empty` are both 1 in the second cycle after the trigger edge, for one cycle.
- R5: A hit whose tag differs from the tag held by its slot discards the slot's old contents. A later read of the old crossing is then empty.
- R6: A slot keeps at most DEPTH words. A hit for a full slot with a matching tag is dropped, and `overflow` rises and stays 1 until reset.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold their values.
- R8: A trigger that arrives while a readout is in progress is ignored.
- R9: A hit sampled at clock edge h is included in a readout whose trigger is sampled at edge h+WR_LAT or later. It is not seen by a trigger sampled at edge h+WR_LAT−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Hit present |
| in_ready | output | 1 | Always 1; the hit input is never stalled |
| in_tag | input | BCO_W | Crossing tag of the hit |
| in_data | input | DATA_W | Hit word |
| bco_now | input | BCO_W | Current crossing counter |
| trig | input | 1 | Readout request, one cycle |
| out_valid | output | 1 | Read word present |
| out_ready | input | 1 | Downstream accepts the read word |
| out_data | output | DATA_W | Read word |
| out_last | output | 1 | Final word of this readout |
| rd_done | output | 1 | One-cycle pulse ending a readout |
| rd_empty | output | 1 | With `rd_done`: the readout had no words |
| overflow | output | 1 | Sticky: a hit was dropped on a full slot |

## Verification
A slot holding the wrong tag or count shows up at the very next readout of that crossing. The symptom is a word count that differs from the model, stale words from an older crossing, or a false empty report. A wrong target subtraction returns another crossing's words, so every expected word carries its own tag and index, and any misrouted word fails on the first compare. The done and empty flags are sampled in the exact cycle the requirements give. Stalled cycles are compared against the word held in the cycle before, so an off-by-one in the readout sequencer or in the write pipeline depth fails within a cycle or two.

// File: rtl/hhb_pkg.sv
package hhb_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_CHECK  = 2'd1,
    RD_STREAM = 2'd2
  } rd_state_e;
endpackage

// File: rtl/hhb_wr_pipe.sv
module hhb_wr_pipe #(
  parameter int DATA_W = 24,
  parameter int BCO_W  = 8,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_valid,
  input  logic [BCO_W-1:0]  i_tag,
  input  logic [DATA_W-1:0] i_data,
  output logic              o_valid,
  output logic [BCO_W-1:0]  o_tag,
  output logic [DATA_W-1:0] o_data
);
  logic              v_q [LAT];
  logic [BCO_W-1:0]  t_q [LAT];
  logic [DATA_W-1:0] d_q [LAT];

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic              v_in;
    logic [BCO_W-1:0]  t_in;
    logic [DATA_W-1:0] d_in;
    if (s == 0) begin : g_head
      assign v_in = i_valid;
      assign t_in = i_tag;
      assign d_in = i_data;
    end else begin : g_body
      assign v_in = v_q[s-1];
      assign t_in = t_q[s-1];
      assign d_in = d_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q[s] <= 1'b0;
        t_q[s] <= '0;
        d_q[s] <= '0;
      end else begin
        v_q[s] <= v_in;
        t_q[s] <= t_in;
        d_q[s] <= d_in;
      end
    end
  end

  assign o_valid = v_q[LAT-1];
  assign o_tag   = t_q[LAT-1];
  assign o_data  = d_q[LAT-1];
endmodule

// File: rtl/hhb_slot_dir.sv
module hhb_slot_dir #(
  parameter int NSLOT = 64,
  parameter int DEPTH = 32,
  parameter int BCO_W = 8,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_valid,
  input  logic [BCO_W-1:0]  c_tag,
  output logic              c_accept,
  output logic [PTR_W-1:0]  c_pos,
  output logic              ovf,
  input  logic [BCO_W-1:0]  q_tag,
  output logic              q_hit,
  output logic [CNT_W-1:0]  q_count
);
  logic             slot_vld [NSLOT];
  logic [BCO_W-1:0] slot_tag [NSLOT];
  logic [CNT_W-1:0] slot_cnt [NSLOT];

  logic [SLOT_W-1:0] c_slot, q_slot;
  logic              fresh, full;

  assign c_slot   = c_tag[SLOT_W-1:0];
  assign q_slot   = q_tag[SLOT_W-1:0];
  assign fresh    = !slot_vld[c_slot] || (slot_tag[c_slot] != c_tag);
  assign full     = (slot_cnt[c_slot] == CNT_W'(DEPTH));
  assign c_accept = c_valid && (fresh || !full);
  assign c_pos    = fresh ? '0 : slot_cnt[c_slot][PTR_W-1:0];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic             sel;
    logic             vld_q;
    logic [BCO_W-1:0] tag_q;
    logic [CNT_W-1:0] cnt_q;
    assign sel = c_valid && (c_slot == SLOT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        cnt_q <= '0;
      end else if (sel) begin
        if (fresh) begin
          vld_q <= 1'b1;
          tag_q <= c_tag;
          cnt_q <= CNT_W'(1);
        end else if (!full) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
    assign slot_vld[g] = vld_q;
    assign slot_tag[g] = tag_q;
    assign slot_cnt[g] = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf <= 1'b0;
    else if (c_valid && !fresh && full) ovf <= 1'b1;
  end

  assign q_hit   = slot_vld[q_slot] && (slot_tag[q_slot] == q_tag);
  assign q_count = slot_cnt[q_slot];

  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  // R6
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

// File: rtl/hhb_store.sv
module hhb_store #(
  parameter int NSLOT  = 64,
  parameter int DEPTH  = 32,
  parameter int DATA_W = 24,
  localparam int ADDR_W = $clog2(NSLOT) + $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NSLOT*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hhb_rd_ctrl.sv
module hhb_rd_ctrl
  import hhb_pkg::*;
#(
  parameter int NSLOT    = 64,
  parameter int DEPTH    = 32,
  parameter int BCO_W    = 8,
  parameter int DATA_W   = 24,
  parameter int TRIG_LAT = 42,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ADDR_W = SLOT_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [BCO_W-1:0]  bco_now,
  output logic [BCO_W-1:0]  q_tag,
  input  logic              q_hit,
  input  logic [CNT_W-1:0]  q_count,
  output logic [ADDR_W-1:0] raddr,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              done,
  output logic              empty
);
  localparam logic [BCO_W-1:0] LAT_V = BCO_W'(TRIG_LAT);

  rd_state_e        state;
  logic [BCO_W-1:0] tgt_tag;
  logic [PTR_W-1:0] rd_pos;
  logic [CNT_W-1:0] rd_left;
  logic             load, finish;

  assign q_tag  = tgt_tag;
  assign raddr  = {tgt_tag[SLOT_W-1:0], rd_pos};
  assign load   = (state == RD_STREAM) && (rd_left != '0) && (!out_valid || out_ready);
  assign finish = out_valid && out_ready && out_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RD_IDLE;
      tgt_tag <= '0;
      rd_pos  <= '0;
      rd_left <= '0;
      done    <= 1'b0;
      empty   <= 1'b0;
    end else begin
      done  <= 1'b0;
      empty <= 1'b0;
      unique case (state)
        RD_IDLE: begin
          if (trig) begin
            tgt_tag <= bco_now - LAT_V;
            state   <= RD_CHECK;
          end
        end
        RD_CHECK: begin
          if (q_hit && (q_count != '0)) begin
            rd_left <= q_count;
            rd_pos  <= '0;
            state   <= RD_STREAM;
          end else begin
            done  <= 1'b1;
            empty <= 1'b1;
            state <= RD_IDLE;
          end
        end
        RD_STREAM: begin
          if (load) begin
            rd_pos  <= rd_pos + PTR_W'(1);
            rd_left <= rd_left - CNT_W'(1);
          end
          if (finish) begin
            done  <= 1'b1;
            state <= RD_IDLE;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= rdata;
      out_last  <= (rd_left == CNT_W'(1));
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R4
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R4
  empty_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> done);

  // R8
  busy_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != RD_IDLE) |=> $stable(tgt_tag));
endmodule

// File: rtl/hit_history_buf.sv
module hit_history_buf #(
  parameter int DATA_W   = 24,
  parameter int BCO_W    = 8,
  parameter int NSLOT    = 64,
  parameter int DEPTH    = 32,
  parameter int TRIG_LAT = 42,
  parameter int WR_LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BCO_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BCO_W-1:0]  bco_now,
  input  logic              trig,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              rd_done,
  output logic              rd_empty,
  output logic              overflow
);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ADDR_W = SLOT_W + PTR_W;

  logic              p_valid;
  logic [BCO_W-1:0]  p_tag;
  logic [DATA_W-1:0] p_data;
  logic              w_accept;
  logic [PTR_W-1:0]  w_pos;
  logic [BCO_W-1:0]  q_tag;
  logic              q_hit;
  logic [CNT_W-1:0]  q_count;
  logic [ADDR_W-1:0] raddr;
  logic [DATA_W-1:0] rdata;

  assign in_ready = 1'b1;

  hhb_wr_pipe #(.DATA_W(DATA_W), .BCO_W(BCO_W), .LAT(WR_LAT)) u_wr_pipe (
    .clk(clk), .rst_n(rst_n),
    .i_valid(in_valid), .i_tag(in_tag), .i_data(in_data),
    .o_valid(p_valid), .o_tag(p_tag), .o_data(p_data)
  );

  hhb_slot_dir #(.NSLOT(NSLOT), .DEPTH(DEPTH), .BCO_W(BCO_W)) u_dir (
    .clk(clk), .rst_n(rst_n),
    .c_valid(p_valid), .c_tag(p_tag), .c_accept(w_accept), .c_pos(w_pos),
    .ovf(overflow),
    .q_tag(q_tag), .q_hit(q_hit), .q_count(q_count)
  );

  hhb_store #(.NSLOT(NSLOT), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(w_accept),
    .waddr({p_tag[SLOT_W-1:0], w_pos}), .wdata(p_data),
    .raddr(raddr), .rdata(rdata)
  );

  hhb_rd_ctrl #(.NSLOT(NSLOT), .DEPTH(DEPTH), .BCO_W(BCO_W), .DATA_W(DATA_W),
                .TRIG_LAT(TRIG_LAT)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .trig(trig), .bco_now(bco_now),
    .q_tag(q_tag), .q_hit(q_hit), .q_count(q_count),
    .raddr(raddr), .rdata(rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(rd_done), .empty(rd_empty)
  );

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
endmodule

// File: tb/hit_history_buf_bench.sv
`timescale 1ns/1ps
module hit_history_buf_bench;
  localparam int DATA_W = 24, BCO_W = 8, NSLOT = 64, DEPTH = 32;
  localparam int TRIG_LAT = 42, WR_LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, trig = 1'b0, out_ready = 1'b1;
  logic [BCO_W-1:0] in_tag = '0, bco_now = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_last, rd_done, rd_empty, overflow;
  logic [DATA_W-1:0] out_data;

  always #2 clk = ~clk;

  hit_history_buf u_hit_history_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_data(in_data), .bco_now(bco_now), .trig(trig),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .rd_done(rd_done), .rd_empty(rd_empty),
    .overflow(overflow)
  );

  int n_chk = 0, n_pass = 0;
  bit finished = 0;

  // per-slot reference model
  logic [DATA_W-1:0] mq [NSLOT][$];
  logic [BCO_W-1:0]  mtag [NSLOT];
  bit                mval [NSLOT];
  bit                exp_ovf = 0;

  // results of the latest readout
  logic [DATA_W-1:0] got_q [$];
  bit                got_last [$];
  int                done_cnt, extra_words;
  bit                empty_seen;

  // {tag, hit count}
  localparam logic [15:0] VEC [6] = '{16'h0503, 16'h1601, 16'h3F05,
                                      16'hFA04, 16'h0002, 16'h4106};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
  endtask

  function automatic void model_add(input logic [BCO_W-1:0] tag, input logic [DATA_W-1:0] d);
    int s = int'(tag[5:0]);
    if (!mval[s] || mtag[s] != tag) begin
      mq[s].delete();
      mtag[s] = tag;
      mval[s] = 1;
    end
    if (mq[s].size() < DEPTH) mq[s].push_back(d);
    else exp_ovf = 1;
  endfunction

  function automatic logic [DATA_W-1:0] mkword(input logic [BCO_W-1:0] tag, input int i, input int seed);
    return {tag, 8'(i), 8'(seed)};
  endfunction

  task automatic write_burst(input logic [BCO_W-1:0] tag, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_tag   = tag;
      in_data  = mkword(tag, i, seed);
      model_add(tag, in_data);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (WR_LAT + 2) @(negedge clk);
  endtask

  task automatic run_read(input logic [BCO_W-1:0] target, input bit toggle, input bit busy_trig);
    bit prev_stall = 0;
    logic [DATA_W-1:0] prev_data = '0;
    logic prev_last = 0;
    bit r;
    got_q.delete();
    got_last.delete();
    done_cnt = 0; extra_words = 0; empty_seen = 0;
    bco_now = target + BCO_W'(TRIG_LAT);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if (busy_trig && c == 2) begin trig = 1'b1; bco_now = bco_now + 8'd5; end
      if (busy_trig && c == 3) trig = 1'b0;
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_last == prev_last,
            "R7", "stalled word held", out_data, prev_data);
      if (rd_done) begin
        done_cnt++;
        empty_seen = rd_empty;
        break;
      end
      r = toggle ? c[0] : 1'b1;
      out_ready = r;
      if (out_valid && r) begin
        got_q.push_back(out_data);
        got_last.push_back(out_last);
      end
      prev_stall = out_valid && !r;
      prev_data  = out_data;
      prev_last  = out_last;
    end
    trig = 1'b0;
    out_ready = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (rd_done) done_cnt++;
      if (out_valid) extra_words++;
    end
  endtask

  task automatic compare_read(input logic [BCO_W-1:0] target, input string req);
    int s = int'(target[5:0]);
    logic [DATA_W-1:0] exp_q [$];
    if (mval[s] && mtag[s] == target) exp_q = mq[s];
    chk(got_q.size() == exp_q.size(), req, "word count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      chk(got_q[i] == exp_q[i], req, "word value", got_q[i], exp_q[i]);
      chk(got_last[i] == (i == exp_q.size() - 1), "R2", "last flag", got_last[i],
          i == exp_q.size() - 1);
    end
    chk(done_cnt == 1 && extra_words == 0, req, "single done, no extra words", done_cnt, 1);
    chk(empty_seen == (exp_q.size() == 0), "R4", "empty flag", empty_seen, exp_q.size() == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) begin mval[s] = 0; mtag[s] = '0; end
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    chk(!out_valid && !rd_done && !rd_empty && !overflow && in_ready, "R1",
        "in reset", {out_valid, rd_done, rd_empty, overflow, in_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !rd_done && !rd_empty && !overflow && in_ready, "R1",
        "after reset", {out_valid, rd_done, rd_empty, overflow, in_ready}, 5'b00001);

    // R2/R3: table-driven fill and readout, including tag 0xFA whose counter wraps
    for (int k = 0; k < 6; k++) begin
      write_burst(VEC[k][15:8], int'(VEC[k][7:0]), k + 1);
    end
    for (int k = 0; k < 6; k++) begin
      run_read(VEC[k][15:8], 1'b0, 1'b0);
      compare_read(VEC[k][15:8], (VEC[k][15:8] == 8'hFA) ? "R3" : "R2");
    end
    chk(!overflow, "R6", "no overflow yet", overflow, 0);

    // R4: never-written crossing, done and empty in second cycle after trigger
    bco_now = 8'h2A + 8'(TRIG_LAT);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(!rd_done && !out_valid, "R4", "first cycle quiet", rd_done, 0);
    @(negedge clk);
    chk(rd_done && rd_empty && !out_valid, "R4", "done+empty timing",
        {rd_done, rd_empty, out_valid}, 3'b110);
    @(negedge clk);
    chk(!rd_done && !rd_empty, "R4", "done is one cycle", {rd_done, rd_empty}, 2'b00);

    // R5: slot 1 holds 0x41; crossing 0x01 is not there, then 0x81 replaces 0x41
    run_read(8'h01, 1'b0, 1'b0);
    compare_read(8'h01, "R5");
    write_burst(8'h81, 2, 9);
    run_read(8'h81, 1'b0, 1'b0);
    compare_read(8'h81, "R5");
    run_read(8'h41, 1'b0, 1'b0);
    chk(got_q.size() == 0 && empty_seen, "R5", "old crossing discarded", got_q.size(), 0);

    // R6: overfill one slot
    write_burst(8'h30, DEPTH + 3, 11);
    chk(overflow && exp_ovf, "R6", "overflow flag", overflow, 1);
    run_read(8'h30, 1'b0, 1'b0);
    compare_read(8'h30, "R6");
    chk(overflow, "R6", "overflow sticky", overflow, 1);

    // R7: back-pressure pattern during readout
    write_burst(8'h50, 4, 13);
    run_read(8'h50, 1'b1, 1'b0);
    compare_read(8'h50, "R7");

    // R8: second trigger during readout is ignored
    write_burst(8'h60, 3, 15);
    run_read(8'h60, 1'b1, 1'b1);
    compare_read(8'h60, "R8");

    // R9: trigger one edge too early misses the hit, on time includes it
    @(negedge clk);
    in_valid = 1'b1; in_tag = 8'h72; in_data = mkword(8'h72, 0, 17);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (WR_LAT - 2) @(negedge clk);
    run_read(8'h72, 1'b0, 1'b0);
    chk(got_q.size() == 0 && empty_seen, "R9", "early trigger misses hit", got_q.size(), 0);
    model_add(8'h72, mkword(8'h72, 0, 17));
    run_read(8'h72, 1'b0, 1'b0);
    compare_read(8'h72, "R9");

    @(negedge clk);
    in_valid = 1'b1; in_tag = 8'h73; in_data = mkword(8'h73, 0, 19);
    model_add(8'h73, in_data);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (WR_LAT - 1) @(negedge clk);
    run_read(8'h73, 1'b0, 1'b0);
    compare_read(8'h73, "R9");

    finished = 1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule